// File: doc/BRIEF.md
# Dual-Page-Size Banked Translation Buffer

This block is a set-associative translation lookaside buffer that keeps 8 KiB base-page and 32 KiB large-page translations in one shared store. The store is split into two banks, and each bank holds every way for its rows. A lookup sends two probes in the same cycle, one looking for a base-page entry and one for a large-page entry. Their bank-select bits are always opposite, so each bank serves exactly one probe and the two never collide. The large probe reuses the base row decode but takes its two lowest row bits from higher virtual-address bits. This means one large entry serves all four base pages of its 32 KiB group.

The caller handles misses. It walks the page table and then presents all four page-table entries of the aligned 32 KiB group, together with the missing virtual address. If the four entries can be merged, the block writes one large entry. Otherwise it writes a base entry for the missing page only. Each set picks its victim with its own round-robin pointer. A flush strobe invalidates every entry in one cycle.

Top module: `dpt_tlb`

## Requirements
- R1: A lookup hitting a base entry returns hit=1, large=0 and a physical address made of the stored 19-bit frame number followed by lookup address bits [12:0].
- R2: A lookup hitting a large entry returns hit=1, large=1 and an address made of stored frame bits [18:2], then lookup address bits [14:13], then bits [12:0]. This holds for every one of the four base pages in the group.
- R3: A fill coalesces when all four valid bits are set, frame number 0 has its two low bits zero, entry i carries frame number 0 plus i, and all four attribute fields are equal. Entry i sits in slice i of the fill buses and belongs to the page whose address bits [14:13] equal i.
- R4: If a fill does not coalesce, the block writes a base entry for the page chosen by fill address bits [14:13], using that entry's frame, as long as that entry's valid bit is set. If that bit is clear, nothing is written.
- R5: The base probe uses bank address bit 16 and row bits [15:13]. The large probe uses the inverted bit 16 as its bank and row {bit 15, bits [18:17]}. Base and large entries that land in the same bank and row compete for the same ways.
- R6: Each bank and row keeps a round-robin victim pointer that steps on every write to that set. With two ways, the third write to a set replaces the first entry written, and other sets are not disturbed.
- R7: A base entry translates only its own 8 KiB page. Lookups to the other three pages of its group miss.
- R8: When the base probe and the large probe both hit, the base entry's result is returned.
- R9: Each lookup strobe gives exactly one cycle of rsp_valid=1 in the following cycle. On a miss, and in any cycle without a response, hit, large and the address are all zero.
- R10: A flush invalidates every entry in one cycle. A fill in the same cycle as a flush is dropped. A lookup in the flush cycle still sees the contents from before the flush.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill. The next lookup sees the new entry.
- R12: After reset every entry is invalid, and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| lookup | input | 1 | Translation request strobe |
| lookup_va | input | 32 | Virtual address to translate |
| fill | input | 1 | Install a translation from the supplied entries |
| fill_va | input | 32 | Virtual address that missed |
| fill_pte_valid | input | 4 | Valid bit per page-table entry of the group |
| fill_ppn | input | 76 | Four 19-bit frame numbers, entry i at [19i +: 19] |
| fill_attr | input | 16 | Four 4-bit attribute fields, entry i at [4i +: 4] |
| rsp_valid | output | 1 | Response present, one cycle after the strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Physical address |
| rsp_large | output | 1 | Result came from a large entry |

## Verification
Two events can land in the same cycle. The first pair is the two probes: they hit together when one base page has its own base entry and its group also has a large entry. The bench sets this up by installing a large group and then filling one of its pages with entries that cannot coalesce. It judges the result by whether the returned address carries the base frame or the large frame, and by the size flag. The second pair is a fill or flush arriving in the same cycle as a lookup. The bench drives these together and checks that the response reflects the old contents while the next lookup reflects the new ones.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  // Base page offset width (8 KiB pages)
  localparam int PG_OFF_W = 13;
  // log2 of the large-to-base page ratio (32 KiB / 8 KiB)
  localparam int GRP_W    = 2;
  localparam int GRP_N    = 1 << GRP_W;

  typedef enum logic {SZ_BASE = 1'b0, SZ_LARGE = 1'b1} page_sz_e;
endpackage

// File: rtl/dpt_index.sv
module dpt_index #(
  parameter int VA_W  = 32,
  parameter int ROW_W = 3
) (
  input  logic [VA_W-1:0]  va,
  output logic             base_bank,
  output logic [ROW_W-1:0] base_row,
  output logic             large_bank,
  output logic [ROW_W-1:0] large_row
);
  import dpt_pkg::*;

  localparam int BANK_BIT = PG_OFF_W + ROW_W;

  function automatic logic [ROW_W-1:0] f_base_row(input logic [VA_W-1:0] a);
    return a[PG_OFF_W +: ROW_W];
  endfunction

  // Low two row bits come from the two VA bits above the bank bit.
  function automatic logic [ROW_W-1:0] f_large_row(input logic [VA_W-1:0] a);
    logic [ROW_W-1:0] r;
    r = f_base_row(a);
    r[GRP_W-1:0] = a[BANK_BIT+1 +: GRP_W];
    return r;
  endfunction

  assign base_bank  = va[BANK_BIT];
  assign large_bank = ~va[BANK_BIT];
  assign base_row   = f_base_row(va);
  assign large_row  = f_large_row(va);
endmodule

// File: rtl/dpt_coalesce.sv
module dpt_coalesce #(
  parameter int PPN_W  = 19,
  parameter int ATTR_W = 4
) (
  input  logic [3:0]          pte_valid,
  input  logic [4*PPN_W-1:0]  pte_ppn,
  input  logic [4*ATTR_W-1:0] pte_attr,
  input  logic [1:0]          sel,
  output logic                make_large,
  output logic                make_base,
  output logic [PPN_W-1:0]    frame
);
  import dpt_pkg::*;

  function automatic logic [PPN_W-1:0] f_ppn(input logic [4*PPN_W-1:0] v, input int i);
    return v[i*PPN_W +: PPN_W];
  endfunction

  function automatic logic [ATTR_W-1:0] f_attr(input logic [4*ATTR_W-1:0] v, input int i);
    return v[i*ATTR_W +: ATTR_W];
  endfunction

  logic contig;
  logic same_attr;
  logic aligned;

  always_comb begin
    contig    = 1'b1;
    same_attr = 1'b1;
    for (int i = 1; i < GRP_N; i++) begin
      if (f_ppn(pte_ppn, i) != f_ppn(pte_ppn, 0) + PPN_W'(i)) contig = 1'b0;
      if (f_attr(pte_attr, i) != f_attr(pte_attr, 0)) same_attr = 1'b0;
    end
    aligned    = (f_ppn(pte_ppn, 0) & PPN_W'(GRP_N - 1)) == '0;
    make_large = (&pte_valid) && contig && same_attr && aligned;
    make_base  = !make_large && pte_valid[sel];
    frame      = make_large ? f_ppn(pte_ppn, 0) : f_ppn(pte_ppn, int'(sel));
  end
endmodule

// File: rtl/dpt_bank.sv
module dpt_bank #(
  parameter int WAYS  = 2,
  parameter int ROW_W = 3,
  parameter int VPN_W = 19,
  parameter int PPN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic             rd_large,
  output logic             rd_hit,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_large,
  input  logic [PPN_W-1:0] wr_ppn
);
  import dpt_pkg::*;

  localparam int ROWS  = 1 << ROW_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  ent_valid [ROWS];
  logic [WAYS-1:0]  ent_large [ROWS];
  logic [VPN_W-1:0] ent_vpn   [ROWS][WAYS];
  logic [PPN_W-1:0] ent_ppn   [ROWS][WAYS];
  logic [WAY_W-1:0] rr_ptr    [ROWS];

  function automatic logic [WAY_W-1:0] f_rr_next(input logic [WAY_W-1:0] p);
    return (int'(p) == WAYS - 1) ? '0 : p + WAY_W'(1);
  endfunction

  // Large entries ignore the in-group page bits of the VPN.
  function automatic logic f_tag_eq(input logic [VPN_W-1:0] a, input logic [VPN_W-1:0] b,
                                    input logic lg);
    if (lg) return a[VPN_W-1:GRP_W] == b[VPN_W-1:GRP_W];
    return a == b;
  endfunction

  logic [WAYS-1:0] way_hit;

  always_comb begin
    rd_hit = 1'b0;
    rd_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      way_hit[w] = ent_valid[rd_row][w] && (ent_large[rd_row][w] == rd_large)
                   && f_tag_eq(ent_vpn[rd_row][w], rd_vpn, rd_large);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        rd_hit = 1'b1;
        rd_ppn = ent_ppn[rd_row][w];
      end
    end
  end

  logic do_write;
  assign do_write = wr_en && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        ent_valid[r] <= '0;
        ent_large[r] <= '0;
        rr_ptr[r]    <= '0;
        for (int w = 0; w < WAYS; w++) begin
          ent_vpn[r][w] <= '0;
          ent_ppn[r][w] <= '0;
        end
      end
    end else if (flush) begin
      for (int r = 0; r < ROWS; r++) ent_valid[r] <= '0;
    end else if (do_write) begin
      ent_valid[wr_row][rr_ptr[wr_row]] <= 1'b1;
      ent_large[wr_row][rr_ptr[wr_row]] <= wr_large;
      ent_vpn[wr_row][rr_ptr[wr_row]]   <= wr_vpn;
      ent_ppn[wr_row][rr_ptr[wr_row]]   <= wr_ppn;
      rr_ptr[wr_row]                    <= f_rr_next(rr_ptr[wr_row]);
    end
  end

  // R6
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> rr_ptr[$past(wr_row)] == f_rr_next($past(rr_ptr[wr_row])));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_hit);

  // R11
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> ent_valid[$past(wr_row)][$past(rr_ptr[wr_row])]);
endmodule

// File: rtl/dpt_tlb.sv
module dpt_tlb #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ATTR_W = 4,
  parameter int ROW_W  = 3,
  parameter int WAYS   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lookup,
  input  logic [VA_W-1:0]        lookup_va,
  input  logic                   fill,
  input  logic [VA_W-1:0]        fill_va,
  input  logic [3:0]             fill_pte_valid,
  input  logic [4*(PA_W-13)-1:0] fill_ppn,
  input  logic [4*ATTR_W-1:0]    fill_attr,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [PA_W-1:0]        rsp_pa,
  output logic                   rsp_large
);
  import dpt_pkg::*;

  localparam int VPN_W = VA_W - PG_OFF_W;
  localparam int PPN_W = PA_W - PG_OFF_W;
  localparam int NBANK = 2;

  function automatic logic [PA_W-1:0] f_base_pa(input logic [PPN_W-1:0] fr,
                                                input logic [VA_W-1:0] va);
    return {fr, va[PG_OFF_W-1:0]};
  endfunction

  function automatic logic [PA_W-1:0] f_large_pa(input logic [PPN_W-1:0] fr,
                                                 input logic [VA_W-1:0] va);
    return {fr[PPN_W-1:GRP_W], va[PG_OFF_W +: GRP_W], va[PG_OFF_W-1:0]};
  endfunction

  // Probe placement for the lookup address and the fill address
  logic             lk_base_bank, lk_large_bank, fl_base_bank, fl_large_bank;
  logic [ROW_W-1:0] lk_base_row, lk_large_row, fl_base_row, fl_large_row;

  dpt_index #(.VA_W(VA_W), .ROW_W(ROW_W)) u_lk_idx (
    .va(lookup_va), .base_bank(lk_base_bank), .base_row(lk_base_row),
    .large_bank(lk_large_bank), .large_row(lk_large_row));

  dpt_index #(.VA_W(VA_W), .ROW_W(ROW_W)) u_fl_idx (
    .va(fill_va), .base_bank(fl_base_bank), .base_row(fl_base_row),
    .large_bank(fl_large_bank), .large_row(fl_large_row));

  // Fill-time coalescing decision
  logic             make_large, make_base;
  logic [PPN_W-1:0] fill_frame;

  dpt_coalesce #(.PPN_W(PPN_W), .ATTR_W(ATTR_W)) u_coal (
    .pte_valid(fill_pte_valid), .pte_ppn(fill_ppn), .pte_attr(fill_attr),
    .sel(fill_va[PG_OFF_W +: GRP_W]), .make_large(make_large),
    .make_base(make_base), .frame(fill_frame));

  logic             bank_hit [NBANK];
  logic [PPN_W-1:0] bank_ppn [NBANK];
  logic             bank_wr  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             serves_large;
    logic [ROW_W-1:0] rd_row;

    // Opposite bank bits: this bank serves the large probe when it is not the base bank.
    assign serves_large = (lk_base_bank != 1'(b));
    assign rd_row       = serves_large ? lk_large_row : lk_base_row;
    assign bank_wr[b]   = fill && ((make_large && (fl_large_bank == 1'(b)))
                                || (make_base && (fl_base_bank == 1'(b))));

    dpt_bank #(.WAYS(WAYS), .ROW_W(ROW_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .rd_row(rd_row), .rd_vpn(lookup_va[VA_W-1:PG_OFF_W]), .rd_large(serves_large),
      .rd_hit(bank_hit[b]), .rd_ppn(bank_ppn[b]),
      .wr_en(bank_wr[b]), .wr_row(make_large ? fl_large_row : fl_base_row),
      .wr_vpn(fill_va[VA_W-1:PG_OFF_W]), .wr_large(make_large), .wr_ppn(fill_frame));
  end

  // Named probe events
  logic             base_hit, large_hit;
  logic [PPN_W-1:0] base_ppn, large_ppn;

  assign base_hit  = bank_hit[lk_base_bank];
  assign large_hit = bank_hit[lk_large_bank];
  assign base_ppn  = bank_ppn[lk_base_bank];
  assign large_ppn = bank_ppn[lk_large_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_large <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lookup;
      rsp_hit   <= lookup && (base_hit || large_hit);
      rsp_large <= lookup && !base_hit && large_hit;
      if (lookup && base_hit)       rsp_pa <= f_base_pa(base_ppn, lookup_va);
      else if (lookup && large_hit) rsp_pa <= f_large_pa(large_ppn, lookup_va);
      else                          rsp_pa <= '0;
    end
  end

  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |=> rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup |=> (!rsp_valid && !rsp_hit && !rsp_large && rsp_pa == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |=> (!rsp_hit || rsp_pa[PG_OFF_W-1:0] == $past(lookup_va[PG_OFF_W-1:0])));

  // R2
  large_grp_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |=> (!rsp_large || rsp_pa[PG_OFF_W +: GRP_W] == $past(lookup_va[PG_OFF_W +: GRP_W])));

  // R8
  base_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && base_hit) |=> (rsp_hit && !rsp_large));

  // R10
  flush_drops_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !lookup) |=> !rsp_hit);
endmodule

// File: tb/dpt_tlb_tb_top.sv
module dpt_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lookup = 1'b0;
  logic [31:0] lookup_va = '0;
  logic        fill = 1'b0;
  logic [31:0] fill_va = '0;
  logic [3:0]  fill_pte_valid = '0;
  logic [75:0] fill_ppn = '0;
  logic [15:0] fill_attr = '0;
  logic        rsp_valid, rsp_hit, rsp_large;
  logic [31:0] rsp_pa;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  dpt_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lookup(lookup), .lookup_va(lookup_va),
    .fill(fill), .fill_va(fill_va), .fill_pte_valid(fill_pte_valid), .fill_ppn(fill_ppn),
    .fill_attr(fill_attr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .rsp_large(rsp_large));

  // Address built from fields: hi=[31:19], g=[18:17], k=[16], m=[15], p=[14:13], offset
  function automatic logic [31:0] mkva(input logic [12:0] hi, input logic [1:0] g,
                                       input logic k, input logic m, input logic [1:0] p,
                                       input logic [12:0] off);
    return {hi, g, k, m, p, off};
  endfunction

  task automatic check(input logic ok, input string req, input logic [34:0] act,
                       input logic [34:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge.
  task automatic look(input logic [31:0] va, input logic eh, input logic el,
                      input logic [31:0] epa, input string req);
    logic [34:0] act, exp;
    lookup = 1'b1; lookup_va = va;
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_large, rsp_pa};
    exp = {1'b1, eh, el, epa};
    check(act == exp, req, act, exp);
    lookup = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [3:0] v,
                         input logic [18:0] p0, input logic [18:0] p1,
                         input logic [18:0] p2, input logic [18:0] p3,
                         input logic [15:0] at);
    fill = 1'b1; fill_va = va; fill_pte_valid = v;
    fill_ppn = {p3, p2, p1, p0}; fill_attr = at;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    logic [34:0] act;
    act = {rsp_valid, rsp_hit, rsp_large, rsp_pa};
    check(act == '0, "R12 reset outputs", act, '0);
    look(mkva(13'd5, 2'd1, 1'b0, 1'b1, 2'd2, 13'h10), 1'b0, 1'b0, 32'h0, "R12 empty miss");
  endtask

  task automatic t_base();
    logic [31:0] va;
    do_flush();
    va = mkva(13'd1, 2'd0, 1'b0, 1'b0, 2'd2, 13'h0);
    do_fill(va, 4'hF, 19'd100, 19'd200, 19'd300, 19'd400, 16'h0000);
    look(va | 32'h123, 1'b1, 1'b0, {19'd300, 13'h123}, "R1 R4 base hit");
    look(mkva(13'd1, 2'd0, 1'b0, 1'b0, 2'd1, 13'h5), 1'b0, 1'b0, 32'h0, "R7 sibling miss");
    look(mkva(13'd1, 2'd0, 1'b0, 1'b0, 2'd3, 13'h5), 1'b0, 1'b0, 32'h0, "R7 sibling miss");
  endtask

  task automatic t_large();
    do_flush();
    do_fill(mkva(13'd2, 2'd1, 1'b1, 1'b0, 2'd3, 13'h0), 4'hF,
            19'h40, 19'h41, 19'h42, 19'h43, 16'h5555);
    for (int i = 0; i < 4; i++) begin
      look(mkva(13'd2, 2'd1, 1'b1, 1'b0, 2'(i), 13'h1ABC), 1'b1, 1'b1,
           {19'h40 + 19'(i), 13'h1ABC}, "R2 R3 large group page");
    end
  endtask

  task automatic t_noqual();
    logic [31:0] va;
    // one invalid entry, selected entry valid
    do_flush();
    va = mkva(13'd3, 2'd0, 1'b0, 1'b0, 2'd0, 13'h0);
    do_fill(va, 4'b1011, 19'h40, 19'h41, 19'h42, 19'h43, 16'h0000);
    look(va, 1'b1, 1'b0, {19'h40, 13'h0}, "R3 R4 invalid member gives base");
    look(mkva(13'd3, 2'd0, 1'b0, 1'b0, 2'd1, 13'h0), 1'b0, 1'b0, 32'h0, "R3 no large entry");
    // misaligned run
    do_flush();
    va = mkva(13'd3, 2'd2, 1'b1, 1'b1, 2'd1, 13'h7);
    do_fill(va, 4'hF, 19'h41, 19'h42, 19'h43, 19'h44, 16'h0000);
    look(va, 1'b1, 1'b0, {19'h42, 13'h7}, "R3 misaligned gives base");
    // attribute mismatch
    do_flush();
    va = mkva(13'd4, 2'd3, 1'b0, 1'b1, 2'd2, 13'h8);
    do_fill(va, 4'hF, 19'h80, 19'h81, 19'h82, 19'h83, 16'h1222);
    look(va, 1'b1, 1'b0, {19'h82, 13'h8}, "R3 attr mismatch gives base");
    look(mkva(13'd4, 2'd3, 1'b0, 1'b1, 2'd0, 13'h8), 1'b0, 1'b0, 32'h0, "R3 attr mismatch no large");
    // non-contiguous
    do_flush();
    va = mkva(13'd6, 2'd0, 1'b1, 1'b0, 2'd3, 13'h9);
    do_fill(va, 4'hF, 19'h80, 19'h81, 19'h90, 19'h83, 16'h0000);
    look(va, 1'b1, 1'b0, {19'h83, 13'h9}, "R3 gap gives base");
    // selected entry invalid: nothing written
    do_flush();
    va = mkva(13'd7, 2'd0, 1'b0, 1'b0, 2'd0, 13'h0);
    do_fill(va, 4'b1110, 19'h40, 19'h41, 19'h42, 19'h43, 16'h0000);
    look(va, 1'b0, 1'b0, 32'h0, "R4 invalid selected entry");
  endtask

  task automatic t_evict();
    logic [31:0] p1, p2, p3, lg;
    do_flush();
    // base set bank0 row 3'b110
    p1 = mkva(13'd10, 2'd0, 1'b0, 1'b1, 2'd2, 13'h0);
    p2 = mkva(13'd11, 2'd0, 1'b0, 1'b1, 2'd2, 13'h0);
    // base set bank1 row 3'b110
    p3 = mkva(13'd10, 2'd0, 1'b1, 1'b1, 2'd2, 13'h0);
    // large set: bank !1 = 0, row {1, 2'b10} = 3'b110
    lg = mkva(13'd12, 2'd2, 1'b1, 1'b1, 2'd0, 13'h0);
    do_fill(p3, 4'b0100, 19'd0, 19'd0, 19'h333, 19'd0, 16'h0);
    do_fill(p1, 4'b0100, 19'd0, 19'd0, 19'h111, 19'd0, 16'h0);
    do_fill(p2, 4'b0100, 19'd0, 19'd0, 19'h222, 19'd0, 16'h0);
    look(p1, 1'b1, 1'b0, {19'h111, 13'h0}, "R6 first of set");
    look(p2, 1'b1, 1'b0, {19'h222, 13'h0}, "R6 second of set");
    do_fill(lg, 4'hF, 19'h100, 19'h101, 19'h102, 19'h103, 16'h0);
    look(p1, 1'b0, 1'b0, 32'h0, "R5 R6 large evicts oldest base");
    look(p2, 1'b1, 1'b0, {19'h222, 13'h0}, "R6 newer base kept");
    look(lg | 32'h4000, 1'b1, 1'b1, {19'h102, 13'h0}, "R5 large in shared set");
    look(p3, 1'b1, 1'b0, {19'h333, 13'h0}, "R5 R6 other bank untouched");
  endtask

  task automatic t_priority();
    logic [31:0] bva;
    do_flush();
    do_fill(mkva(13'd20, 2'd0, 1'b0, 1'b0, 2'd0, 13'h0), 4'hF,
            19'h80, 19'h81, 19'h82, 19'h83, 16'h0);
    bva = mkva(13'd20, 2'd0, 1'b0, 1'b0, 2'd1, 13'h0);
    do_fill(bva, 4'hF, 19'h81, 19'h999, 19'h82, 19'h83, 16'h0);
    look(bva | 32'h55, 1'b1, 1'b0, {19'h999, 13'h55}, "R8 base wins over large");
    look(mkva(13'd20, 2'd0, 1'b0, 1'b0, 2'd2, 13'h55), 1'b1, 1'b1, {19'h82, 13'h55},
         "R8 large still serves others");
  endtask

  task automatic t_latency();
    logic [34:0] act;
    do_flush();
    do_fill(mkva(13'd30, 2'd0, 1'b0, 1'b0, 2'd0, 13'h0), 4'b0001, 19'h7, 19'h0, 19'h0, 19'h0, 16'h0);
    look(mkva(13'd30, 2'd0, 1'b0, 1'b0, 2'd0, 13'h1), 1'b1, 1'b0, {19'h7, 13'h1}, "R9 response");
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_large, rsp_pa};
    check(act == '0, "R9 single cycle response", act, '0);
  endtask

  task automatic t_flush();
    logic [31:0] va;
    logic [34:0] act, exp;
    do_flush();
    va = mkva(13'd40, 2'd1, 1'b1, 1'b0, 2'd1, 13'h0);
    do_fill(va, 4'b0010, 19'h0, 19'h44, 19'h0, 19'h0, 16'h0);
    // lookup in the flush cycle sees old contents
    flush = 1'b1; lookup = 1'b1; lookup_va = va;
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_large, rsp_pa};
    exp = {3'b110, 19'h44, 13'h0};
    check(act == exp, "R10 lookup during flush", act, exp);
    flush = 1'b0; lookup = 1'b0;
    look(va, 1'b0, 1'b0, 32'h0, "R10 flushed");
    // fill together with flush is dropped
    flush = 1'b1;
    do_fill(va, 4'b0010, 19'h0, 19'h44, 19'h0, 19'h0, 16'h0);
    flush = 1'b0;
    look(va, 1'b0, 1'b0, 32'h0, "R10 fill dropped by flush");
  endtask

  task automatic t_same_cycle();
    logic [31:0] va;
    logic [34:0] act, exp;
    do_flush();
    va = mkva(13'd50, 2'd2, 1'b0, 1'b1, 2'd3, 13'h0);
    lookup = 1'b1; lookup_va = va | 32'h20;
    fill = 1'b1; fill_va = va; fill_pte_valid = 4'hF;
    fill_ppn = {19'h203, 19'h202, 19'h201, 19'h200}; fill_attr = 16'h0;
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_large, rsp_pa};
    exp = {3'b100, 32'h0};
    check(act == exp, "R11 lookup during fill sees old", act, exp);
    lookup = 1'b0; fill = 1'b0;
    look(va | 32'h20, 1'b1, 1'b1, {19'h203, 13'h20}, "R11 next lookup sees fill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_large();
    t_noqual();
    t_evict();
    t_priority();
    t_latency();
    t_flush();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule